// File: doc/BRIEF.md
# Floating-Point Rounding and Range Stage

This block is the last step of a floating-point datapath. It receives a result held at full working precision: a sign, a signed unbiased exponent, a 64-bit significand with an explicit leading one, and a guard bit and a sticky bit for what lies below it. It rounds that value to single, double or extended precision under one of four rounding modes. It then checks the rounded value against the range of the chosen format and packs it into that format's bit layout. Along with the packed word it raises overflow, underflow and inexact flags, which the status register accumulates.

The value presented is (-1)^sign x (significand / 2^63) x 2^exponent. A non-zero significand must have its top bit set. A significand of zero means an exact zero. Results too small for the format are not made subnormal: they become a zero of the same sign. The stage is one register deep. Each input beat marked valid appears, rounded, on the outputs one clock later.

Top module: `fp_round_stage`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid`, `out_result` and all three flags read zero.
- R2: A beat accepted with `in_valid` high appears on the outputs after exactly one rising edge, with `out_valid` high. When `in_valid` is low at an edge, `out_valid` goes low and the result and flags keep their previous values.
- R3: Mode 2'b00 (nearest) rounds to the nearer representable value. When the discarded part is exactly one half of the last place, the result is the neighbour whose least significant kept bit is 0.
- R4: Mode 2'b01 rounds toward plus infinity, mode 2'b10 toward minus infinity and mode 2'b11 toward zero. A directed mode moves the magnitude up only when the discarded part is non-zero and the direction points away from zero for that sign.
- R5: Precision 2'b00 gives a 32-bit word in `out_result[31:0]`: sign at bit 31, 8-bit exponent with bias 127, 23 fraction bits. Precision 2'b01 gives a 64-bit word in `out_result[63:0]`: sign at bit 63, 11-bit exponent with bias 1023, 52 fraction bits. Precision 2'b10 gives an 80-bit word: sign at bit 79, 15-bit exponent with bias 16383, and the full 64-bit significand with its leading bit explicit. Precision 2'b11 behaves as 2'b10. Unused upper bits are zero.
- R6: When rounding up carries out of the kept significand, the significand becomes 1.000... and the exponent rises by one.
- R7: Overflow is decided on the exponent after rounding. A value below the format's largest finite number can still overflow if rounding lifts it past that limit.
- R8: When the rounded exponent exceeds the format's maximum, `out_overflow` is raised and the result is a signed substitute. Nearest mode, and directed modes that round away from zero for that sign, produce infinity. Toward-zero mode, and directed modes that round toward zero for that sign, produce the largest finite number. Infinity has an all-ones exponent and a zero fraction; in extended precision its explicit leading bit is 1.
- R9: `out_inexact` is raised when the rounded result differs from the exact input. On overflow it is raised only if `in_ovf_trap_en` is low; an enabled overflow trap suppresses inexact.
- R10: A rounded exponent below the format's smallest normal exponent (1 - bias) gives a zero with the input's sign, and raises both `out_underflow` and `out_inexact`.
- R11: A zero significand gives a zero of the input's sign with no flags raised, whatever the guard and sticky bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | 64 | Significand with explicit leading one |
| in_guard | input | 1 | First bit below the significand |
| in_sticky | input | 1 | OR of all bits below the guard bit |
| in_prec | input | 2 | Destination format select |
| in_mode | input | 2 | Rounding mode |
| in_ovf_trap_en | input | 1 | Overflow trap enabled |
| out_valid | output | 1 | Output beat present |
| out_result | output | 80 | Packed rounded result |
| out_overflow | output | 1 | Overflow detected |
| out_underflow | output | 1 | Result flushed to zero |
| out_inexact | output | 1 | Result not exact |

## Verification
The round-up carry and the overflow decision can fall on the same beat. This happens when a significand whose kept bits are all ones sits at the format's maximum exponent and rounding pushes it over. The sweep causes this in every format by pairing an all-ones significand with each pattern of last-place, round and sticky bits at the maximum exponent, under all four modes and both signs. The outcome is judged on two things: whether overflow is flagged only when the mode actually rounded up, and whether the substitute value and the inexact flag follow the mode, the sign and the trap enable.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  localparam int MANT_W  = 64;
  localparam int XEXP_W  = 15;
  localparam int RES_W   = 1 + XEXP_W + MANT_W;
  localparam int SGL_SIG = 24;
  localparam int SGL_EXP = 8;
  localparam int DBL_SIG = 53;
  localparam int DBL_EXP = 11;
  localparam int NFMT    = 3;

  typedef enum logic [1:0] {
    RM_NEAR  = 2'b00,
    RM_UP    = 2'b01,
    RM_DOWN  = 2'b10,
    RM_TRUNC = 2'b11
  } rmode_e;

  // Format index: 0 single, 1 double, 2 extended (select 3 folds onto 2).
  function automatic int fmt_index(input logic [1:0] p);
    return (p == 2'b11) ? 2 : int'(p);
  endfunction

  function automatic int fmt_sig(input int f);
    return (f == 0) ? SGL_SIG : (f == 1) ? DBL_SIG : MANT_W;
  endfunction

  function automatic int fmt_exp(input int f);
    return (f == 0) ? SGL_EXP : (f == 1) ? DBL_EXP : XEXP_W;
  endfunction

  function automatic int fmt_bias(input int f);
    return (1 << (fmt_exp(f) - 1)) - 1;
  endfunction

endpackage

// File: rtl/fpr_select.sv
// Splits the working significand at the destination's last place.
module fpr_select
  import fpr_pkg::*;
#(
  parameter int MANT_W = fpr_pkg::MANT_W
) (
  input  logic [MANT_W-1:0] mant,
  input  logic              guard,
  input  logic              sticky,
  input  logic [1:0]        prec,
  output logic [MANT_W-1:0] kept,
  output logic [MANT_W-1:0] unit,
  output logic              lsb,
  output logic              rbit,
  output logic              sbit
);
  localparam int SH_W = $clog2(MANT_W);

  logic [SH_W-1:0]   drop;
  logic [MANT_W-1:0] below;

  always_comb begin
    drop  = SH_W'(MANT_W - fmt_sig(fmt_index(prec)));
    unit  = {{(MANT_W-1){1'b0}}, 1'b1} << drop;
    below = unit - 1'b1;
    kept  = mant & ~below;
    lsb   = |(mant & unit);
    if (drop == '0) begin
      rbit = guard;
      sbit = sticky;
    end else begin
      rbit = |(mant & (unit >> 1));
      sbit = guard | sticky | (|(mant & (below >> 1)));
    end
  end

endmodule

// File: rtl/fpr_incr.sv
// Rounding decision, increment and carry renormalisation.
module fpr_incr
  import fpr_pkg::*;
#(
  parameter int MANT_W = fpr_pkg::MANT_W,
  parameter int EXP_W  = 18
) (
  input  logic [MANT_W-1:0]     kept,
  input  logic [MANT_W-1:0]     unit,
  input  logic                  lsb,
  input  logic                  rbit,
  input  logic                  sbit,
  input  logic                  sign,
  input  logic [1:0]            mode,
  input  logic signed [EXP_W-1:0] exp_in,
  output logic [MANT_W-1:0]     sig_out,
  output logic signed [EXP_W:0] exp_out,
  output logic                  carry,
  output logic                  inexact_raw
);
  logic            bump;
  logic [MANT_W:0] sum;

  always_comb begin
    inexact_raw = rbit | sbit;
    unique case (mode)
      RM_NEAR: bump = rbit & (lsb | sbit);
      RM_UP:   bump = inexact_raw & ~sign;
      RM_DOWN: bump = inexact_raw & sign;
      default: bump = 1'b0;
    endcase
    sum     = {1'b0, kept} + ({1'b0, unit} & {(MANT_W+1){bump}});
    carry   = sum[MANT_W];
    sig_out = carry ? sum[MANT_W:1] : sum[MANT_W-1:0];
    exp_out = {exp_in[EXP_W-1], exp_in} + {{EXP_W{1'b0}}, carry};
  end

endmodule

// File: rtl/fpr_pack.sv
// Range check, overflow substitution and per-format packing.
module fpr_pack
  import fpr_pkg::*;
#(
  parameter int MANT_W = fpr_pkg::MANT_W,
  parameter int EXP_W  = 18,
  parameter int RES_W  = fpr_pkg::RES_W
) (
  input  logic                  sign,
  input  logic [MANT_W-1:0]     sig,
  input  logic signed [EXP_W:0] exp_r,
  input  logic [1:0]            prec,
  input  logic [1:0]            mode,
  input  logic                  inexact_raw,
  input  logic                  is_zero,
  input  logic                  trap_en,
  output logic [RES_W-1:0]      result,
  output logic                  ovf,
  output logic                  ufl,
  output logic                  inx
);
  localparam int EW = EXP_W + 1;

  logic signed [EW-1:0] emax;
  logic signed [EW-1:0] emin;
  logic [XEXP_W-1:0]    biased;
  logic                 to_inf;
  logic [RES_W-1:0]     cand [NFMT];

  always_comb begin
    emax   = EW'(fmt_bias(fmt_index(prec)));
    emin   = EW'(1 - fmt_bias(fmt_index(prec)));
    ovf    = !is_zero && (exp_r > emax);
    ufl    = !is_zero && (exp_r < emin);
    to_inf = (mode == RM_NEAR) || (mode == RM_UP && !sign) || (mode == RM_DOWN && sign);
    biased = XEXP_W'(exp_r + EW'(fmt_bias(fmt_index(prec))));
    if (is_zero)  inx = 1'b0;
    else if (ovf) inx = ~trap_en;
    else if (ufl) inx = 1'b1;
    else          inx = inexact_raw;
  end

  for (genvar f = 0; f < NFMT; f++) begin : g_fmt
    localparam int FE   = fmt_exp(f);
    localparam int SKIP = (f == NFMT - 1) ? 0 : 1;
    localparam int FRAC = fmt_sig(f) - SKIP;
    localparam int W    = 1 + FE + FRAC;
    logic [W-1:0] word;
    always_comb begin
      if (is_zero || ufl)
        word = {sign, {(W-1){1'b0}}};
      else if (ovf && to_inf)
        word = {sign, {FE{1'b1}}, (SKIP == 0), {(FRAC-1){1'b0}}};
      else if (ovf)
        word = {sign, {(FE-1){1'b1}}, 1'b0, {FRAC{1'b1}}};
      else
        word = {sign, biased[FE-1:0], sig[MANT_W-1-SKIP -: FRAC]};
    end
    assign cand[f] = RES_W'(word);
  end

  assign result = cand[fmt_index(prec)];

endmodule

// File: rtl/fp_round_stage.sv
module fp_round_stage
  import fpr_pkg::*;
#(
  parameter int EXP_W = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sign,
  input  logic [EXP_W-1:0]     in_exp,
  input  logic [MANT_W-1:0]    in_mant,
  input  logic                 in_guard,
  input  logic                 in_sticky,
  input  logic [1:0]           in_prec,
  input  logic [1:0]           in_mode,
  input  logic                 in_ovf_trap_en,
  output logic                 out_valid,
  output logic [RES_W-1:0]     out_result,
  output logic                 out_overflow,
  output logic                 out_underflow,
  output logic                 out_inexact
);
  logic [MANT_W-1:0]     kept, unit, sig_rnd;
  logic                  lsb, rbit, sbit, carry, inexact_raw;
  logic signed [EXP_W:0] exp_rnd;
  logic [RES_W-1:0]      nxt_result;
  logic                  nxt_ovf, nxt_ufl, nxt_inx;
  logic                  is_zero;

  assign is_zero = (in_mant == '0);

  fpr_select #(.MANT_W(MANT_W)) u_select (
    .mant(in_mant), .guard(in_guard), .sticky(in_sticky), .prec(in_prec),
    .kept(kept), .unit(unit), .lsb(lsb), .rbit(rbit), .sbit(sbit)
  );

  fpr_incr #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_incr (
    .kept(kept), .unit(unit), .lsb(lsb), .rbit(rbit), .sbit(sbit),
    .sign(in_sign), .mode(in_mode), .exp_in(in_exp),
    .sig_out(sig_rnd), .exp_out(exp_rnd), .carry(carry), .inexact_raw(inexact_raw)
  );

  // Carry out of the increment must leave exactly the leading one.
  AST_CARRY_RENORM: assert property (@(posedge clk) disable iff (rst)
    (carry && !is_zero) |-> sig_rnd == {1'b1, {(MANT_W-1){1'b0}}}); // R6
  // With nothing discarded, rounding must leave the kept bits untouched.
  AST_EXACT_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(rbit || sbit) |-> (sig_rnd == kept && !carry)); // R9

  fpr_pack #(.MANT_W(MANT_W), .EXP_W(EXP_W), .RES_W(RES_W)) u_pack (
    .sign(in_sign), .sig(sig_rnd), .exp_r(exp_rnd), .prec(in_prec), .mode(in_mode),
    .inexact_raw(inexact_raw), .is_zero(is_zero), .trap_en(in_ovf_trap_en),
    .result(nxt_result), .ovf(nxt_ovf), .ufl(nxt_ufl), .inx(nxt_inx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
      out_inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result    <= nxt_result;
        out_overflow  <= nxt_ovf;
        out_underflow <= nxt_ufl;
        out_inexact   <= nxt_inx;
      end
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result))); // R2
  AST_RANGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(out_overflow && out_underflow)); // R10
  AST_FLUSH_INEXACT: assert property (@(posedge clk) disable iff (rst)
    out_underflow |-> out_inexact); // R10

endmodule

// File: tb/fp_round_stage_bench.sv
module fp_round_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_W      = 18;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_sign = 1'b0;
  logic [EXP_W-1:0]  in_exp = '0;
  logic [63:0]       in_mant = '0;
  logic              in_guard = 1'b0;
  logic              in_sticky = 1'b0;
  logic [1:0]        in_prec = '0;
  logic [1:0]        in_mode = '0;
  logic              in_ovf_trap_en = 1'b0;
  logic              out_valid;
  logic [79:0]       out_result;
  logic              out_overflow, out_underflow, out_inexact;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_round_stage #(.EXP_W(EXP_W)) u_fp_round_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign), .in_exp(in_exp),
    .in_mant(in_mant), .in_guard(in_guard), .in_sticky(in_sticky), .in_prec(in_prec),
    .in_mode(in_mode), .in_ovf_trap_en(in_ovf_trap_en), .out_valid(out_valid),
    .out_result(out_result), .out_overflow(out_overflow), .out_underflow(out_underflow),
    .out_inexact(out_inexact)
  );

  task automatic check(input string tag, input logic [82:0] got, input logic [82:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Reference: arithmetic rounding of {mant,guard,sticky} viewed as one integer.
  task automatic model(input int pr, input int md, input bit sg, input int e_in,
                       input logic [63:0] m, input bit g, input bit s, input bit tr,
                       output logic [79:0] res, output bit ovf, output bit ufl,
                       output bit inx, output bit cy, output bit tie);
    int p, eb, fb, bias, sh, e;
    logic [65:0] ext, rem, half;
    logic [64:0] q;
    bit up, toinf;
    p    = (pr == 0) ? 24 : (pr == 1) ? 53 : 64;
    eb   = (pr == 0) ? 8  : (pr == 1) ? 11 : 15;
    fb   = (pr == 2 || pr == 3) ? 64 : p - 1;
    bias = (1 << (eb - 1)) - 1;
    sh   = 64 - p + 2;
    ext  = {m, g, s};
    q    = 65'(ext >> sh);
    rem  = ext & ((66'd1 << sh) - 66'd1);
    half = 66'd1 << (sh - 1);
    tie  = (rem == half);
    case (md)
      0: up = (rem > half) || (tie && q[0]);
      1: up = (rem != 0) && !sg;
      2: up = (rem != 0) && sg;
      default: up = 1'b0;
    endcase
    q  = q + 65'(up);
    e  = e_in;
    cy = (q == (65'd1 << p));
    if (cy) begin q = q >> 1; e = e + 1; end
    res = 80'(sg) << (eb + fb);
    ovf = 1'b0; ufl = 1'b0; inx = (rem != 0);
    if (m == 0) begin
      inx = 1'b0; cy = 1'b0;
    end else if (e > bias) begin
      ovf   = 1'b1;
      inx   = !tr;
      toinf = (md == 0) || (md == 1 && !sg) || (md == 2 && sg);
      if (toinf)
        res = res | (80'((1 << eb) - 1) << fb) | ((fb == 64) ? (80'd1 << 63) : 80'd0);
      else
        res = res | (80'((1 << eb) - 2) << fb) | ((80'd1 << fb) - 80'd1);
    end else if (e < 1 - bias) begin
      ufl = 1'b1;
      inx = 1'b1;
    end else begin
      res = res | (80'(e + bias) << fb) | (80'(q) & ((80'd1 << fb) - 80'd1));
    end
  endtask

  task automatic run_case(input int pr, input int md, input bit sg, input int e_in,
                          input int pat, input bit tr);
    logic [63:0] m;
    bit g, s, ovf, ufl, inx, cy, tie;
    logic [79:0] res;
    int p, sh, bias;
    string tag;
    p    = (pr == 0) ? 24 : (pr == 1) ? 53 : 64;
    sh   = 64 - p;
    bias = (pr == 0) ? 127 : (pr == 1) ? 1023 : 16383;
    m = pat[3] ? {64{1'b1}} : (64'd1 << 63);
    g = 1'b0; s = 1'b0;
    if (sh == 0) begin
      m[0] = pat[0]; g = pat[1]; s = pat[2];
    end else begin
      m = m & ~((64'd1 << (sh + 1)) - 64'd1);
      m[sh] = pat[0]; m[sh-1] = pat[1]; m[0] = pat[2];
    end
    model(pr, md, sg, e_in, m, g, s, tr, res, ovf, ufl, inx, cy, tie);
    @(negedge clk);
    in_valid = 1'b1; in_sign = sg; in_exp = EXP_W'(e_in); in_mant = m;
    in_guard = g; in_sticky = s; in_prec = 2'(pr); in_mode = 2'(md); in_ovf_trap_en = tr;
    @(negedge clk);
    if (ufl)                    tag = "R10";
    else if (ovf && e_in == bias) tag = "R7";
    else if (ovf)               tag = "R8";
    else if (cy)                tag = "R6";
    else if (md == 0 && tie)    tag = "R3";
    else if (md != 0)           tag = "R4";
    else                        tag = "R5";
    check(tag, {out_valid, out_result, out_overflow, out_underflow},
               {1'b1, res, ovf, ufl});
    check("R9", 83'(out_inexact), 83'(inx));
  endtask

  initial begin
    logic [79:0] held;
    repeat (3) @(negedge clk);
    check("R1", {out_valid, out_result, out_overflow, out_underflow}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {out_valid, out_result, out_overflow, out_underflow, out_inexact}, '0);

    for (int pr = 0; pr < 4; pr++)
      for (int md = 0; md < 4; md++)
        for (int sg = 0; sg < 2; sg++)
          for (int ei = 0; ei < 6; ei++)
            for (int pat = 0; pat < 16; pat++)
              for (int tr = 0; tr < 2; tr++) begin
                int b, e;
                b = (pr == 0) ? 127 : (pr == 1) ? 1023 : 16383;
                case (ei)
                  0: e = 0;
                  1: e = b;
                  2: e = 1 - b;
                  3: e = -b;
                  4: e = b + 1;
                  default: e = -3;
                endcase
                run_case(pr, md, sg[0], e, pat, tr[0]);
              end

    // R11: zero significand gives signed zero, no flags, guard/sticky ignored.
    for (int pr = 0; pr < 3; pr++)
      for (int sg = 0; sg < 2; sg++) begin
        int sp;
        sp = (pr == 0) ? 31 : (pr == 1) ? 63 : 79;
        @(negedge clk);
        in_valid = 1'b1; in_sign = sg[0]; in_mant = '0; in_guard = 1'b1; in_sticky = 1'b1;
        in_prec = 2'(pr); in_mode = 2'b01; in_exp = EXP_W'(5);
        @(negedge clk);
        check("R11", {out_result, out_overflow, out_underflow, out_inexact},
                     {80'(sg) << sp, 3'b000});
      end

    // R2: idle beats change nothing and drop out_valid.
    held = out_result;
    @(negedge clk);
    in_valid = 1'b0; in_mant = 64'hC000_0000_0000_0000; in_sign = 1'b0; in_exp = '0;
    in_prec = 2'b10;
    @(negedge clk);
    check("R2", {out_valid, out_result}, {1'b0, held});
    @(negedge clk);
    check("R2", {out_valid, out_result}, {1'b0, held});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule